// File: doc/BRIEF.md
# Scanline Interrupt Counter

This block counts rendered video lines down from a value the CPU programs, and raises a level interrupt to the CPU after that many lines. A separate timing block supplies a one-cycle tick for each scanline, the current line number, and a flag that is high while background or sprite drawing is on. Only ticks on visible lines, while drawing is on, count.

The CPU talks to the block through a write strobe, a 2-bit register select and an 8-bit data byte. Select 0 stores the data byte as the reload value. Select 1 arms a reload, which is applied on the next counted line. Select 2 turns interrupts off and acknowledges a pending request. Select 3 turns interrupts on and also acknowledges. Each time the counter reaches zero it arms a fresh reload from the stored value. With a reload value of N, the interrupt therefore repeats every N+1 counted lines.

Top module: `scanline_irq_counter`

## Requirements
- R1: After reset, interrupts are off, the reload value, counter and reload-armed flag are zero, and `irq_o` is low. With interrupts enabled, the first counted line after reset (counter already zero) asserts `irq_o`.
- R2: A write with select 0 stores `wr_data_i` as the reload value. A write with select 1 arms a reload that takes the stored value and never the data byte of that write.
- R3: A tick counts only when `line_i` is below 240 and `render_i` is high. Any other tick leaves the counter unchanged.
- R4: On a counted line with a reload armed, the counter takes the stored value and the armed flag clears. Otherwise a nonzero counter decrements by one.
- R5: When the counter is zero after a counted line, a reload is armed again. A reload value N therefore gives a request every N+1 counted lines.
- R6: A counted line that leaves the counter at zero sets the request only while interrupts are enabled. Once set, `irq_o` stays high until a select 2 or select 3 write.
- R7: A select 2 write disables interrupts and clears `irq_o`. A select 3 write enables interrupts and clears `irq_o`. `irq_o` is low on the cycle after either write.
- R8: When a select 2 or 3 write falls in the same cycle as a counted line that reaches zero, the write wins and `irq_o` stays low.
- R9: A reload armed while the line number is 240 or higher is applied on the first counted line of the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | CPU register write strobe, one cycle |
| reg_sel_i | input | 2 | 0 reload value, 1 arm reload, 2 disable and ack, 3 enable and ack |
| wr_data_i | input | 8 | Write data byte |
| tick_i | input | 1 | One-cycle pulse per scanline |
| line_i | input | 9 | Current scanline number |
| render_i | input | 1 | Background or sprite drawing enabled |
| irq_o | output | 1 | Interrupt request, active high, level |

## Verification
The bench sweeps reload values 0 through 15. For each value it checks the line on which the first request appears and the line on which the auto-reloaded repeat appears. A wrong load or decrement step shows up as a shift in the first of these lines. A missing re-arm shows up in the second.

Off-screen ticks and ticks with drawing off are interleaved with counted ticks, which separates the line gate from the counter itself. A reload armed during blanking checks that the armed flag survives until the next frame. Acknowledge writes on the exact cycle of a zero, and a count that runs while interrupts are disabled, show whether the write side wins and whether the enable gate acts on setting the request or on counting.

// File: rtl/scanline_irq_pkg.sv
`timescale 1ns/1ps
package scanline_irq_pkg;
  typedef enum logic [1:0] {
    SEL_LATCH   = 2'd0,
    SEL_RELOAD  = 2'd1,
    SEL_DISABLE = 2'd2,
    SEL_ENABLE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/scanline_irq_regs.sv
`timescale 1ns/1ps
module scanline_irq_regs
  import scanline_irq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       reg_sel_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic [CNT_W-1:0] latch_o,
  output logic             enable_o,
  output logic             reload_req_o,
  output logic             ack_o
);
  reg_sel_e sel;
  assign sel = reg_sel_e'(reg_sel_i);

  assign reload_req_o = wr_en_i && (sel == SEL_RELOAD);
  assign ack_o        = wr_en_i && ((sel == SEL_DISABLE) || (sel == SEL_ENABLE));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_o  <= '0;
      enable_o <= 1'b0;
    end else if (wr_en_i) begin
      case (sel)
        SEL_LATCH:   latch_o  <= wr_data_i;
        SEL_DISABLE: enable_o <= 1'b0;
        SEL_ENABLE:  enable_o <= 1'b1;
        default:     ;
      endcase
    end
  end

  a_r7_enable_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> (enable_o == $past(reg_sel_i[0])));
endmodule

// File: rtl/scanline_irq_count.sv
`timescale 1ns/1ps
module scanline_irq_count #(
  parameter int CNT_W     = 8,
  parameter int LINE_W    = 9,
  parameter int VIS_LINES = 240
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic              render_i,
  input  logic [CNT_W-1:0]  latch_i,
  input  logic              reload_req_i,
  output logic              zero_hit_o
);
  localparam logic [LINE_W-1:0] VisEnd = LINE_W'(VIS_LINES);

  logic             count_en;
  logic [CNT_W-1:0] cnt_q, cnt_step;
  logic             pend_q, pend_step;

  assign count_en = tick_i && render_i && (line_i < VisEnd);

  always_comb begin
    cnt_step  = cnt_q;
    pend_step = pend_q;
    if (pend_q) begin
      cnt_step  = latch_i;
      pend_step = 1'b0;
    end else if (cnt_q != '0) begin
      cnt_step = cnt_q - 1'b1;
    end
  end

  assign zero_hit_o = count_en && (cnt_step == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else if (count_en) begin
      cnt_q  <= cnt_step;
      // zero re-arms; a reload write in the same cycle also arms
      pend_q <= pend_step || (cnt_step == '0) || reload_req_i;
    end else if (reload_req_i) begin
      pend_q <= 1'b1;
    end
  end

  a_r3_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !count_en |=> $stable(cnt_q));
  a_r4_decrement: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_en && !pend_q && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
  a_r4_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_en && pend_q) |=> (cnt_q == $past(latch_i)));
  a_r5_rearm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_en && !pend_q && cnt_q == CNT_W'(1)) |=> pend_q);
endmodule

// File: rtl/scanline_irq_req.sv
`timescale 1ns/1ps
module scanline_irq_req (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic zero_hit_i,
  input  logic enable_i,
  input  logic ack_i,
  output logic irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     irq_o <= 1'b0;
    else if (ack_i)                  irq_o <= 1'b0;  // ack wins over a same-cycle zero
    else if (zero_hit_i && enable_i) irq_o <= 1'b1;
  end

  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !ack_i) |=> irq_o);
  a_r7_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> !irq_o);
  a_r6_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(enable_i && zero_hit_i));
endmodule

// File: rtl/scanline_irq_counter.sv
`timescale 1ns/1ps
module scanline_irq_counter #(
  parameter int CNT_W     = 8,
  parameter int LINE_W    = 9,
  parameter int VIS_LINES = 240
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        reg_sel_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  input  logic              tick_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic              render_i,
  output logic              irq_o
);
  logic [CNT_W-1:0] latch;
  logic             enable, reload_req, ack, zero_hit;

  scanline_irq_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .reg_sel_i, .wr_data_i,
    .latch_o(latch), .enable_o(enable), .reload_req_o(reload_req), .ack_o(ack)
  );

  scanline_irq_count #(.CNT_W(CNT_W), .LINE_W(LINE_W), .VIS_LINES(VIS_LINES)) u_count (
    .clk_i, .rst_ni, .tick_i, .line_i, .render_i,
    .latch_i(latch), .reload_req_i(reload_req), .zero_hit_o(zero_hit)
  );

  scanline_irq_req u_req (
    .clk_i, .rst_ni, .zero_hit_i(zero_hit), .enable_i(enable), .ack_i(ack),
    .irq_o
  );
endmodule

// File: tb/scanline_irq_counter_tb.sv
`timescale 1ns/1ps
module scanline_irq_counter_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] sel = '0;
  logic [7:0] data = '0;
  logic       tick = 1'b0;
  logic [8:0] line = '0;
  logic       render = 1'b0;
  logic       irq;
  int         n_chk = 0;
  int         n_fail = 0;

  always #10 clk = ~clk;

  scanline_irq_counter u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .reg_sel_i(sel),
    .wr_data_i(data), .tick_i(tick), .line_i(line), .render_i(render),
    .irq_o(irq)
  );

  task automatic check(input logic exp, input string req);
    n_chk++;
    if (irq !== exp) begin
      n_fail++;
      $display("FAIL %s: irq_o=%b expected %b at %0t", req, irq, exp, $time);
    end
  endtask

  // one cycle with optional tick and optional write, sampled on the next negedge
  task automatic step(input logic t, input int ln, input logic rd,
                      input logic w, input logic [1:0] s, input logic [7:0] d);
    tick = t; line = 9'(ln); render = rd; wr_en = w; sel = s; data = d;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    step(1'b0, 0, 1'b1, 1'b1, s, d);
  endtask

  task automatic ln(input int n, input logic rd);
    step(1'b1, n, rd, 1'b0, 2'd0, 8'd0);
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog: irq_o=%b expected completion", irq);
    $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(1'b0, "R1 reset");
    for (int i = 0; i < 20; i++) ln(i, 1'b1);
    check(1'b0, "R1 disabled after reset");
    wr(2'd3, 8'h00);
    ln(20, 1'b1);
    check(1'b1, "R1 zero counter at reset");
    wr(2'd2, 8'h00);
    check(1'b0, "R7 disable clears");

    // sweep reload values: first request after N+1 lines, repeat after 2N+2
    for (int n = 0; n < 16; n++) begin
      wr(2'd0, 8'(n));
      wr(2'd1, 8'(n) ^ 8'hA5);
      wr(2'd3, 8'h00);
      check(1'b0, "R7 enable clears");
      for (int k = 1; k <= n + 1; k++) begin
        ln(k % 240, 1'b1);
        check(k == n + 1, "R2 R4 first request");
      end
      wr(2'd3, 8'h00);
      check(1'b0, "R7 ack");
      for (int k = n + 2; k <= 2 * n + 2; k++) begin
        ln(k % 240, 1'b1);
        check(k == 2 * n + 2, "R5 auto reload period");
      end
      wr(2'd3, 8'h00);
    end

    // R3: ignored ticks interleaved with counted ones, latch 3 -> fires on 4th counted
    wr(2'd0, 8'd3);
    wr(2'd1, 8'd0);
    ln(240, 1'b1); ln(261, 1'b1); ln(10, 1'b0);
    ln(0, 1'b1);
    ln(241, 1'b1); ln(5, 1'b0);
    ln(1, 1'b1); ln(2, 1'b1);
    check(1'b0, "R3 gated ticks not counted");
    ln(250, 1'b1); ln(3, 1'b0);
    ln(3, 1'b1);
    check(1'b1, "R3 fires on fourth counted line");
    ln(4, 1'b0); ln(245, 1'b1);
    check(1'b1, "R6 request holds");
    wr(2'd3, 8'h00);
    ln(5, 1'b1);   // consumes the auto reload: counter 3, nothing armed
    check(1'b0, "R4 reload does not fire");

    // R9: reload armed in blanking is used on first line of next frame
    wr(2'd0, 8'd1);
    step(1'b1, 245, 1'b1, 1'b1, 2'd1, 8'h00);
    ln(255, 1'b1);
    ln(0, 1'b1);
    check(1'b0, "R9 loaded in new frame");
    ln(1, 1'b1);
    check(1'b1, "R9 fires second line");
    wr(2'd2, 8'h00);

    // R6: count runs while disabled, no request
    wr(2'd0, 8'd2);
    wr(2'd1, 8'h00);
    for (int k = 0; k < 3; k++) begin
      ln(k, 1'b1);
      check(1'b0, "R6 no request while disabled");
    end
    wr(2'd3, 8'h00);
    ln(3, 1'b1); ln(4, 1'b1);
    check(1'b0, "R6 counting after enable");
    ln(5, 1'b1);
    check(1'b1, "R6 request once enabled");

    // R8: ack on the same cycle as a zero wins
    wr(2'd0, 8'd1);
    wr(2'd1, 8'h00);
    wr(2'd3, 8'h00);
    ln(6, 1'b1);
    step(1'b1, 7, 1'b1, 1'b1, 2'd3, 8'h00);
    check(1'b0, "R8 enable-ack wins over zero");
    ln(8, 1'b1);
    ln(9, 1'b1);
    check(1'b1, "R8 still enabled after ack");
    wr(2'd3, 8'h00);
    ln(10, 1'b1);
    step(1'b1, 11, 1'b1, 1'b1, 2'd2, 8'h00);
    check(1'b0, "R8 disable-ack wins over zero");
    ln(12, 1'b1); ln(13, 1'b1);
    check(1'b0, "R7 disable holds");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule